// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode, ALU, memory, writeback) copes with the instructions now in flight. It compares the source registers of the instruction in decode with the destinations of the older instructions in the ALU and memory stages. It watches the branch outcome that the ALU stage resolves. From these it drives hold lines for the program counter and the decode register, a bubble request for the ALU stage, squash lines for the two younger stages, and the operand source selects used by the ALU-stage instruction.

Forwarding is decided one stage early. The select for each operand is worked out while the consumer sits in decode, then registered as the consumer moves into the ALU stage. At that point the producer that was in the ALU stage has moved to memory, and the one that was in memory has moved to writeback. A load followed at once by a user of its result holds fetch and decode for one cycle and sends a bubble forward. The released consumer then takes the loaded value from writeback. A taken branch or jump squashes the two younger instructions. That squash overrides any stall raised in the same cycle.

Top module: `hzd_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both operand selects read 2'b00, which means the register file.
- R2: If a used decode source equals the ALU-stage destination, that destination is written, it is not register 0, and the decode instruction advances, then the matching select reads 2'b10 (memory stage) one cycle later.
- R3: If a used decode source equals the memory-stage destination, that destination is written and nonzero, the ALU stage does not also match, and the instruction advances, then the select reads 2'b01 (writeback stage) one cycle later.
- R4: If both the ALU-stage and the memory-stage destinations match a source, the select one cycle later reads 2'b10, so the younger producer wins.
- R5: If the ALU-stage instruction is a written load whose destination matches a used decode source, then pc_hold, id_hold and ex_bubble are high in the same cycle, and both selects read 2'b00 one cycle later.
- R6: After a load-use stall the held consumer advances on the next cycle, with the load now in the memory stage, and its select then reads 2'b01.
- R7: A source or destination of register 0 never raises a stall and never gives a select other than 2'b00.
- R8: When the ALU stage reports a taken branch or jump, if_flush and id_flush are high in that cycle, and both selects read 2'b00 one cycle later.
- R9: When a taken branch and a load-use match occur in the same cycle, the flush lines are high and pc_hold, id_hold and ex_bubble are low.
- R10: A decode source whose use flag is low never forwards and never stalls.
- R11: A producer whose write enable is low never forwards and never stalls.
- R12: With no match and no taken branch, all hold, bubble and flush outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_rd | input | REG_W | Destination of the ALU-stage instruction |
| ex_wen | input | 1 | ALU-stage instruction writes a register |
| ex_load | input | 1 | ALU-stage instruction is a load |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| ex_taken | input | 1 | ALU stage resolved a taken branch or jump |
| pc_hold | output | 1 | Hold the program counter |
| id_hold | output | 1 | Hold the decode register |
| ex_bubble | output | 1 | Send a bubble into the ALU stage next cycle |
| if_flush | output | 1 | Squash the fetch-stage instruction |
| id_flush | output | 1 | Squash the decode-stage instruction |
| fwd_a | output | 2 | First operand source of the ALU-stage instruction: 00 register file, 01 writeback, 10 memory |
| fwd_b | output | 2 | Second operand source of the ALU-stage instruction, same encoding |

## Verification
The bench targets the double match, where a design that checks writeback first would feed a stale value. It covers the load-use case and the cycle after it: a design that forwards the load at once, or forgets to switch the held consumer over to writeback, would hand the ALU a value that does not exist yet or an old copy. Register 0, cleared use flags and cleared write enables are driven with matching numbers, to catch a design that stalls or forwards on a name alone. A taken branch is paired with a load-use match, so that a design letting the stall win would freeze the wrong-path instructions instead of squashing them.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rs,
  input  logic             rs_used,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  output logic             hit_ex,
  output logic             hit_mem,
  output logic             load_hit,
  output fwd_sel_e         sel_next
);
  // a source depends on a producer only through a real, written, nonzero name
  function automatic logic reads_from(input logic [REG_W-1:0] src, input logic used,
                                      input logic [REG_W-1:0] dst, input logic wen);
    return used && wen && (src != '0) && (src == dst);
  endfunction

  // nearer producer (one stage ahead) is the newest value
  function automatic fwd_sel_e pick(input logic near, input logic far);
    if (near) return FWD_MEM;
    if (far)  return FWD_WB;
    return FWD_RF;
  endfunction

  assign hit_ex   = reads_from(rs, rs_used, ex_rd, ex_wen);
  assign hit_mem  = reads_from(rs, rs_used, mem_rd, mem_wen);
  assign load_hit = hit_ex && ex_load;
  assign sel_next = pick(hit_ex, hit_mem);
endmodule

// File: rtl/hzd_steer.sv
module hzd_steer (
  input  logic load_hit_any,
  input  logic taken,
  output logic pc_hold,
  output logic id_hold,
  output logic ex_bubble,
  output logic if_flush,
  output logic id_flush,
  output logic advance
);
  logic stall;

  // redirect outranks the load-use stall
  assign stall     = load_hit_any && !taken;
  assign pc_hold   = stall;
  assign id_hold   = stall;
  assign ex_bubble = stall;
  assign if_flush  = taken;
  assign id_flush  = taken;
  assign advance   = !stall && !taken;
endmodule

// File: rtl/hzd_fwd_reg.sv
module hzd_fwd_reg
  import hzd_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     advance,
  input  fwd_sel_e sel_next [N],
  output fwd_sel_e sel_q    [N]
);
  for (genvar g = 0; g < N; g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel_q[g] <= FWD_RF;
      else if (advance) sel_q[g] <= sel_next[g];
      else              sel_q[g] <= FWD_RF;
    end
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             ex_taken,
  output logic             pc_hold,
  output logic             id_hold,
  output logic             ex_bubble,
  output logic             if_flush,
  output logic             id_flush,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b
);
  logic [REG_W-1:0] src_id  [NSRC];
  logic             src_use [NSRC];
  logic [NSRC-1:0]  hit_ex_v;
  logic [NSRC-1:0]  hit_mem_v;
  logic [NSRC-1:0]  load_hit_v;
  fwd_sel_e         sel_next [NSRC];
  fwd_sel_e         sel_q    [NSRC];

  // named events for the checker
  logic load_use_hit;
  logic advance;

  assign src_id[0]  = id_rs1;
  assign src_id[1]  = id_rs2;
  assign src_use[0] = id_use_rs1;
  assign src_use[1] = id_use_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_src_match #(.REG_W(REG_W)) u_match (
      .rs       (src_id[g]),
      .rs_used  (src_use[g]),
      .ex_rd    (ex_rd),
      .ex_wen   (ex_wen),
      .ex_load  (ex_load),
      .mem_rd   (mem_rd),
      .mem_wen  (mem_wen),
      .hit_ex   (hit_ex_v[g]),
      .hit_mem  (hit_mem_v[g]),
      .load_hit (load_hit_v[g]),
      .sel_next (sel_next[g])
    );
  end

  assign load_use_hit = |load_hit_v;

  hzd_steer u_steer (
    .load_hit_any (load_use_hit),
    .taken        (ex_taken),
    .pc_hold      (pc_hold),
    .id_hold      (id_hold),
    .ex_bubble    (ex_bubble),
    .if_flush     (if_flush),
    .id_flush     (id_flush),
    .advance      (advance)
  );

  hzd_fwd_reg #(.N(NSRC)) u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .sel_next (sel_next),
    .sel_q    (sel_q)
  );

  assign fwd_a = sel_q[0];
  assign fwd_b = sel_q[1];

  logic unused_hits;
  assign unused_hits = ^{hit_ex_v, hit_mem_v};
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic             id_use_rs1,
  input logic             id_use_rs2,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_wen,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_wen,
  input logic             ex_taken,
  input logic             pc_hold,
  input logic             id_hold,
  input logic             ex_bubble,
  input logic             if_flush,
  input logic             id_flush,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             load_use_hit,
  input logic             advance
);
  a_r8_flush_both: assert property (@(posedge clk) disable iff (!rst_n)
    ex_taken |-> (if_flush && id_flush));

  a_r9_flush_beats_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ex_taken |-> (!pc_hold && !id_hold && !ex_bubble));

  a_r5_load_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (load_use_hit && !ex_taken) |-> (pc_hold && id_hold && ex_bubble));

  a_r5_bubble_clears_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  a_r8_flush_clears_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    ex_taken |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  a_r7_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |=> (fwd_a == 2'b00));

  a_r4_near_first: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && id_use_rs1 && id_rs1 != '0 && ex_wen && ex_rd == id_rs1) |=> (fwd_a == 2'b10));

  a_r3_far_only: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && id_use_rs2 && id_rs2 != '0 && mem_wen && mem_rd == id_rs2 &&
     !(ex_wen && ex_rd == id_rs2)) |=> (fwd_b == 2'b01));

  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .id_rs1       (id_rs1),
  .id_rs2       (id_rs2),
  .id_use_rs1   (id_use_rs1),
  .id_use_rs2   (id_use_rs2),
  .ex_rd        (ex_rd),
  .ex_wen       (ex_wen),
  .mem_rd       (mem_rd),
  .mem_wen      (mem_wen),
  .ex_taken     (ex_taken),
  .pc_hold      (pc_hold),
  .id_hold      (id_hold),
  .ex_bubble    (ex_bubble),
  .if_flush     (if_flush),
  .id_flush     (id_flush),
  .fwd_a        (fwd_a),
  .fwd_b        (fwd_b),
  .load_use_hit (load_use_hit),
  .advance      (advance)
);

// File: tb/hzd_ctrl_test.sv
module hzd_ctrl_test;
  localparam int PERIOD = 10;
  localparam int RW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [RW-1:0] id_rs1 = 0, id_rs2 = 0, ex_rd = 0, mem_rd = 0;
  logic id_use_rs1 = 0, id_use_rs2 = 0, ex_wen = 0, ex_load = 0, mem_wen = 0, ex_taken = 0;
  logic pc_hold, id_hold, ex_bubble, if_flush, id_flush;
  logic [1:0] fwd_a, fwd_b;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  hzd_ctrl #(.REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_load(ex_load), .mem_rd(mem_rd), .mem_wen(mem_wen), .ex_taken(ex_taken),
    .pc_hold(pc_hold), .id_hold(id_hold), .ex_bubble(ex_bubble), .if_flush(if_flush),
    .id_flush(id_flush), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // true dependence on a producer: name equal, producer writes, name is not r0, source used
  function automatic bit needs(int src, bit used, int dst, bit wen);
    if (src == 0) return 0;
    if (!used) return 0;
    if (!wen) return 0;
    return src == dst;
  endfunction

  function automatic bit lu_now();
    return ex_load && (needs(id_rs1, id_use_rs1, ex_rd, ex_wen) ||
                       needs(id_rs2, id_use_rs2, ex_rd, ex_wen));
  endfunction

  // code for the next ALU-stage operand: 2 memory, 1 writeback, 0 file
  function automatic int code_for(int src, bit used);
    int c = 0;
    if (needs(src, used, mem_rd, mem_wen)) c = 1;
    if (needs(src, used, ex_rd, ex_wen)) c = 2;
    return c;
  endfunction

  function automatic string classify();
    bit lu = lu_now();
    if (ex_taken && lu) return "R9";
    if (ex_taken) return "R8";
    if (lu) return "R5";
    if (code_for(id_rs1, id_use_rs1) == 2 && needs(id_rs1, id_use_rs1, mem_rd, mem_wen)) return "R4";
    if (code_for(id_rs1, id_use_rs1) == 2 || code_for(id_rs2, id_use_rs2) == 2) return "R2";
    if (code_for(id_rs1, id_use_rs1) == 1 || code_for(id_rs2, id_use_rs2) == 1) return "R3";
    return "R12";
  endfunction

  // inputs are set; check this cycle's steering, then next cycle's selects
  task automatic apply(string tag);
    bit lu, stall;
    int ea, eb;
    #1;
    lu = lu_now();
    stall = lu && !ex_taken;
    chk(tag, "pc_hold", pc_hold, stall);
    chk(tag, "id_hold", id_hold, stall);
    chk(tag, "ex_bubble", ex_bubble, stall);
    chk(tag, "if_flush", if_flush, ex_taken);
    chk(tag, "id_flush", id_flush, ex_taken);
    if (stall || ex_taken) begin
      ea = 0; eb = 0;
    end else begin
      ea = code_for(id_rs1, id_use_rs1);
      eb = code_for(id_rs2, id_use_rs2);
    end
    @(negedge clk);
    chk(tag, "fwd_a", fwd_a, ea);
    chk(tag, "fwd_b", fwd_b, eb);
  endtask

  task automatic clear();
    id_rs1 = 0; id_rs2 = 0; ex_rd = 0; mem_rd = 0;
    id_use_rs1 = 0; id_use_rs2 = 0; ex_wen = 0; ex_load = 0; mem_wen = 0; ex_taken = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    clear();
    repeat (3) @(negedge clk);
    chk("R1", "fwd_a in reset", fwd_a, 0);
    chk("R1", "fwd_b in reset", fwd_b, 0);
    rst_n = 1;
    #1;
    chk("R1", "fwd_a after reset", fwd_a, 0);
    chk("R1", "fwd_b after reset", fwd_b, 0);
    @(negedge clk);

    clear(); apply("R12");
    clear(); id_rs1 = 3; id_use_rs1 = 1; id_rs2 = 3; id_use_rs2 = 1; ex_rd = 3; ex_wen = 1; apply("R2");
    clear(); id_rs2 = 4; id_use_rs2 = 1; mem_rd = 4; mem_wen = 1; apply("R3");
    clear(); id_rs1 = 5; id_use_rs1 = 1; ex_rd = 5; ex_wen = 1; mem_rd = 5; mem_wen = 1; apply("R4");
    clear(); id_rs2 = 6; id_use_rs2 = 1; ex_rd = 6; ex_wen = 1; ex_load = 1; apply("R5");
    clear(); id_rs2 = 6; id_use_rs2 = 1; mem_rd = 6; mem_wen = 1; apply("R6");
    clear(); id_use_rs1 = 1; ex_wen = 1; ex_load = 1; mem_wen = 1; apply("R7");
    clear(); id_rs1 = 2; id_use_rs1 = 1; ex_rd = 2; ex_wen = 1; ex_taken = 1; apply("R8");
    clear(); id_rs1 = 9; id_use_rs1 = 1; ex_rd = 9; ex_wen = 1; ex_load = 1; ex_taken = 1; apply("R9");
    clear(); id_rs1 = 7; ex_rd = 7; ex_wen = 1; ex_load = 1; id_rs2 = 8; mem_rd = 8; mem_wen = 1; apply("R10");
    clear(); id_rs1 = 7; id_use_rs1 = 1; ex_rd = 7; ex_load = 1; id_rs2 = 8; id_use_rs2 = 1; mem_rd = 8; apply("R11");

    for (int i = 0; i < 3000; i++) begin
      id_rs1 = RW'($urandom_range(0, 3));
      id_rs2 = RW'($urandom_range(0, 3));
      ex_rd = RW'($urandom_range(0, 3));
      mem_rd = RW'($urandom_range(0, 3));
      id_use_rs1 = ($urandom_range(0, 9) < 8);
      id_use_rs2 = ($urandom_range(0, 9) < 7);
      ex_wen = ($urandom_range(0, 3) != 0);
      mem_wen = ($urandom_range(0, 3) != 0);
      ex_load = ($urandom_range(0, 9) < 3);
      ex_taken = ($urandom_range(0, 9) == 0);
      apply(classify());
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule